// File: doc/BRIEF.md
# Dual Halfword Signed Multiply-Accumulate Unit

This unit splits each of two 32-bit operands into a low and a high signed 16-bit lane, forms two 16x16 signed products and merges them into one 32-bit signed result. The mode inputs pick one of two operations, sum or difference of the two products. They can also swap the two halves of operand b before multiplying, and add a 32-bit accumulator value c to the merged products. The result is not saturated. It wraps modulo 2^32.

A sticky overflow flag records any signed overflow of either 32-bit addition: the product sum and the accumulator add. The flag stays set until the clear input is raised or reset is applied. Each operation is presented with a one-cycle valid strobe. The result, its valid strobe and the flag are registered and appear on the clock edge that samples the operation.

Top module: `dmac_dual16`

## Requirements
- R1: After synchronous reset, res_o is 0, res_vld_o is 0 and q_o is 0.
- R2: With sub_i=0, xchg_i=0, acc_i=0, the result is a0*b0 + a1*b1. Lane 0 is bits [15:0] and lane 1 is bits [31:16], each a two's-complement value. For a=(1,2) and b=(5,4) the result is 13.
- R3: With xchg_i=1, operand b's lanes are swapped, so the sum form gives a0*b1 + a1*b0. For the same inputs it gives 14.
- R4: With sub_i=1, the result is a0*b0 - a1*b1, which gives -3 for the R2 inputs. With xchg_i=1 as well, it is a0*b1 - a1*b0, which gives -6.
- R5: With acc_i=1, c_i is added to the product result, wrapping modulo 2^32. For a=(1,2), b=(3,4), c=10 this gives 21 in sum form and 5 in difference form.
- R6: res_o and res_vld_o=1 appear on the clock edge that samples valid_i=1. res_vld_o is 0 after an edge that samples valid_i=0.
- R7: q_o becomes 1 when the product sum overflows 32-bit signed range. The only such case is sum form with all four multiplied lanes equal to -32768. The wrapped result is 0x80000000.
- R8: q_o becomes 1 when adding c_i to the product result overflows 32-bit signed range.
- R9: q_o, once set, stays 1 through any number of operations that do not overflow, for as long as q_clr_i is 0.
- R10: q_clr_i=1 makes q_o 0 on the next edge, unless the same edge samples an overflowing valid operation. In that case q_o is 1.
- R11: While valid_i=0, the inputs a_i, b_i, c_i and the mode bits have no effect: res_o holds and q_o changes only through q_clr_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| sub_i | input | 1 | 1: difference of products, 0: sum |
| xchg_i | input | 1 | 1: swap halves of operand b |
| acc_i | input | 1 | 1: add c_i to the result |
| q_clr_i | input | 1 | Clear the sticky overflow flag |
| a_i | input | 32 | Operand a, two signed 16-bit lanes |
| b_i | input | 32 | Operand b, two signed 16-bit lanes |
| c_i | input | 32 | Accumulator addend |
| res_o | output | 32 | Registered signed result |
| res_vld_o | output | 1 | Result valid strobe |
| q_o | output | 1 | Sticky overflow flag |

## Verification
A clear request and a new overflow can land on the same edge, and the flag update has to resolve which one wins. The sweep raises q_clr_i on every seventh operation while valid operations keep running. Some of those operations pair two -32768 lanes or use a near-limit accumulator value, so clears coincide with fresh overflows. A directed step also forces the collision on purpose. The flag is judged each cycle against a bench model that first drops the old flag on a clear and then ORs in the new overflow, so a set must survive the clear.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef struct packed {
    logic sub;
    logic xchg;
    logic acc;
  } dmac_mode_t;

  // Signed overflow of r = x + y (or x - y when y_msb is pre-inverted)
  function automatic logic add_ovf(input logic x_msb, input logic y_msb,
                                   input logic r_msb);
    return (x_msb == y_msb) && (r_msb != x_msb);
  endfunction

endpackage

// File: rtl/dmac_lane_mul.sv
module dmac_lane_mul #(
  parameter int LW = 16
) (
  input  logic signed [LW-1:0]   a_i,
  input  logic signed [LW-1:0]   b_i,
  output logic signed [2*LW-1:0] prod_o
);
  always_comb begin
    prod_o = a_i * b_i;
  end
endmodule

// File: rtl/dmac_pair_combine.sv
module dmac_pair_combine
  import dmac_pkg::*;
#(
  parameter int PW = 32
) (
  input  logic [PW-1:0] p0_i,
  input  logic [PW-1:0] p1_i,
  input  logic          sub_i,
  output logic [PW-1:0] sum_o,
  output logic          ovf_o
);
  logic p1_eff_msb;

  always_comb begin
    sum_o      = sub_i ? (p0_i - p1_i) : (p0_i + p1_i);
    // a subtraction behaves like adding an operand of opposite sign
    p1_eff_msb = sub_i ? ~p1_i[PW-1] : p1_i[PW-1];
    ovf_o      = add_ovf(p0_i[PW-1], p1_eff_msb, sum_o[PW-1]);
  end
endmodule

// File: rtl/dmac_acc_add.sv
module dmac_acc_add
  import dmac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] c_i,
  input  logic         en_i,
  output logic [W-1:0] y_o,
  output logic         ovf_o
);
  logic [W-1:0] addend;

  always_comb begin
    addend = en_i ? c_i : '0;
    y_o    = x_i + addend;
    ovf_o  = add_ovf(x_i[W-1], addend[W-1], y_o[W-1]);
  end
endmodule

// File: rtl/dmac_dual16.sv
module dmac_dual16
  import dmac_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  valid_i,
  input  logic                  sub_i,
  input  logic                  xchg_i,
  input  logic                  acc_i,
  input  logic                  q_clr_i,
  input  logic [2*LANE_W-1:0]   a_i,
  input  logic [2*LANE_W-1:0]   b_i,
  input  logic [2*LANE_W-1:0]   c_i,
  output logic [2*LANE_W-1:0]   res_o,
  output logic                  res_vld_o,
  output logic                  q_o
);
  localparam int WORD_W = 2 * LANE_W;
  localparam int NLANE  = 2;

  dmac_mode_t mode;
  logic [WORD_W-1:0] prod [NLANE];
  logic [WORD_W-1:0] pair_sum;
  logic [WORD_W-1:0] acc_sum;
  logic              pair_ovf;
  logic              acc_ovf;

  always_comb begin
    mode.sub  = sub_i;
    mode.xchg = xchg_i;
    mode.acc  = acc_i;
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W-1:0] a_l;
    logic [LANE_W-1:0] b_l;
    assign a_l = a_i[g*LANE_W +: LANE_W];
    assign b_l = mode.xchg ? b_i[(NLANE-1-g)*LANE_W +: LANE_W]
                           : b_i[g*LANE_W +: LANE_W];
    dmac_lane_mul #(.LW(LANE_W)) u_mul (
      .a_i    (a_l),
      .b_i    (b_l),
      .prod_o (prod[g])
    );
  end

  dmac_pair_combine #(.PW(WORD_W)) u_comb (
    .p0_i  (prod[0]),
    .p1_i  (prod[1]),
    .sub_i (mode.sub),
    .sum_o (pair_sum),
    .ovf_o (pair_ovf)
  );

  dmac_acc_add #(.W(WORD_W)) u_acc (
    .x_i   (pair_sum),
    .c_i   (c_i),
    .en_i  (mode.acc),
    .y_o   (acc_sum),
    .ovf_o (acc_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      res_vld_o <= 1'b0;
      q_o       <= 1'b0;
    end else begin
      res_vld_o <= valid_i;
      if (valid_i) res_o <= acc_sum;
      // a fresh overflow outranks a clear on the same edge
      q_o <= (q_o & ~q_clr_i) | (valid_i & (pair_ovf | acc_ovf));
    end
  end
endmodule

// File: rtl/dmac_dual16_chk.sv
module dmac_dual16_chk #(
  parameter int LANE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                valid_i,
  input logic                sub_i,
  input logic                q_clr_i,
  input logic [2*LANE_W-1:0] a_i,
  input logic [2*LANE_W-1:0] b_i,
  input logic [2*LANE_W-1:0] res_o,
  input logic                res_vld_o,
  input logic                q_o
);
  localparam logic [2*LANE_W-1:0] MIN_PAIR = {2{1'b1, {(LANE_W-1){1'b0}}}};

  // R6
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> res_vld_o);
  // R6
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !res_vld_o);
  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(res_o));
  // R9
  q_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (q_o && !q_clr_i) |=> q_o);
  // R10
  q_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (q_clr_i && !valid_i) |=> !q_o);
  // R7
  pair_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !sub_i && a_i == MIN_PAIR && b_i == MIN_PAIR) |=> q_o);
endmodule

bind dmac_dual16 dmac_dual16_chk #(.LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid_i   (valid_i),
  .sub_i     (sub_i),
  .q_clr_i   (q_clr_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .res_o     (res_o),
  .res_vld_o (res_vld_o),
  .q_o       (q_o)
);

// File: tb/dmac_dual16_bench.sv
`timescale 1ns/1ps
module dmac_dual16_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0, sub_i = 1'b0, xchg_i = 1'b0, acc_i = 1'b0, q_clr_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0, c_i = '0;
  logic [31:0] res_o;
  logic        res_vld_o, q_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_res = '0;
  logic        exp_q   = 1'b0;

  always #2.5 clk = ~clk;

  dmac_dual16 u_dmac_dual16 (
    .clk(clk), .rst(rst), .valid_i(valid_i), .sub_i(sub_i), .xchg_i(xchg_i),
    .acc_i(acc_i), .q_clr_i(q_clr_i), .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .res_o(res_o), .res_vld_o(res_vld_o), .q_o(q_o)
  );

  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                input logic [31:0] c, input logic sub,
                                input logic x, input logic acc,
                                output logic [31:0] r, output logic ovf);
    logic signed [15:0] a0, a1, m0, m1;
    logic signed [31:0] w, cs;
    longint p0, p1, s, t;
    a0 = a[15:0];
    a1 = a[31:16];
    m0 = x ? b[31:16] : b[15:0];
    m1 = x ? b[15:0]  : b[31:16];
    p0 = longint'(a0) * longint'(m0);
    p1 = longint'(a1) * longint'(m1);
    s  = sub ? p0 - p1 : p0 + p1;
    ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    w  = s[31:0];
    cs = c;
    t  = longint'(w) + (acc ? longint'(cs) : 64'sd0);
    if ((t > 64'sd2147483647) || (t < -64'sd2147483648)) ovf = 1'b1;
    r = t[31:0];
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c, input logic sub, input logic x,
                       input logic acc, input logic clr, input string tag);
    logic [31:0] r;
    logic ovf;
    @(negedge clk);
    valid_i = v; a_i = a; b_i = b; c_i = c;
    sub_i = sub; xchg_i = x; acc_i = acc; q_clr_i = clr;
    model(a, b, c, sub, x, acc, r, ovf);
    if (v) exp_res = r;
    exp_q = (exp_q & ~clr) | (v & ovf);
    @(posedge clk);
    #1;
    check(res_o === exp_res, tag, "result", res_o, exp_res);
    check(res_vld_o === v, tag, "valid", {31'd0, res_vld_o}, {31'd0, v});
    check(q_o === exp_q, tag, "Q", {31'd0, q_o}, {31'd0, exp_q});
  endtask

  logic [15:0] vals [7];
  logic [31:0] cvals [4];

  initial begin
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'hFFFF; vals[3] = 16'h7FFF;
    vals[4] = 16'h8000; vals[5] = 16'h0002; vals[6] = 16'hFED4;
    cvals[0] = 32'd0; cvals[1] = 32'd10; cvals[2] = 32'h7FFF_FFFF; cvals[3] = 32'h8000_0000;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1
    check(res_o === 32'd0, "R1", "result", res_o, 32'd0);
    check(res_vld_o === 1'b0, "R1", "valid", {31'd0, res_vld_o}, 32'd0);
    check(q_o === 1'b0, "R1", "Q", {31'd0, q_o}, 32'd0);

    issue(1, {16'd2, 16'd1}, {16'd4, 16'd5}, 0, 0, 0, 0, 0, "R2");
    check(res_o === 32'd13, "R2", "example", res_o, 32'd13);
    issue(1, {16'd2, 16'd1}, {16'd4, 16'd5}, 0, 0, 1, 0, 0, "R3");
    check(res_o === 32'd14, "R3", "example", res_o, 32'd14);
    issue(1, {16'd2, 16'd1}, {16'd4, 16'd5}, 0, 1, 0, 0, 0, "R4");
    check(res_o === -32'sd3, "R4", "example", res_o, -32'sd3);
    issue(1, {16'd2, 16'd1}, {16'd4, 16'd5}, 0, 1, 1, 0, 0, "R4");
    check(res_o === -32'sd6, "R4", "exchanged", res_o, -32'sd6);
    issue(1, {16'd2, 16'd1}, {16'd4, 16'd3}, 10, 0, 0, 1, 0, "R5");
    check(res_o === 32'd21, "R5", "sum", res_o, 32'd21);
    issue(1, {16'd2, 16'd1}, {16'd4, 16'd3}, 10, 1, 0, 1, 0, "R5");
    check(res_o === 32'd5, "R5", "difference", res_o, 32'd5);

    // R7 pair overflow
    issue(1, 32'h8000_8000, 32'h8000_8000, 0, 0, 0, 0, 0, "R7");
    check(res_o === 32'h8000_0000 && q_o === 1'b1, "R7", "wrap", res_o, 32'h8000_0000);
    // R9 sticky
    issue(1, {16'd2, 16'd1}, {16'd4, 16'd5}, 0, 0, 0, 0, 0, "R9");
    check(q_o === 1'b1, "R9", "sticky", {31'd0, q_o}, 32'd1);
    // R11 inputs ignored while idle
    issue(0, 32'hDEAD_BEEF, 32'h8000_8000, 32'h7FFF_FFFF, 1, 1, 1, 0, "R11");
    check(res_o === 32'd13, "R11", "hold", res_o, 32'd13);
    // R10 clear alone
    issue(0, 0, 0, 0, 0, 0, 0, 1, "R10");
    check(q_o === 1'b0, "R10", "clear", {31'd0, q_o}, 32'd0);
    // R11 idle overflow pattern does not set Q
    issue(0, 32'h8000_8000, 32'h8000_8000, 0, 0, 0, 0, 0, "R11");
    check(q_o === 1'b0, "R11", "idle Q", {31'd0, q_o}, 32'd0);
    // R8 accumulator overflow
    issue(1, {16'd0, 16'h7FFF}, {16'd0, 16'h7FFF}, 32'h7FFF_FFFF, 0, 0, 1, 0, "R8");
    check(q_o === 1'b1, "R8", "acc ovf", {31'd0, q_o}, 32'd1);
    issue(0, 0, 0, 0, 0, 0, 0, 1, "R10");
    // R10 clear and overflow on one edge
    issue(1, 32'h8000_8000, 32'h8000_8000, 0, 0, 1, 0, 1, "R10");
    check(q_o === 1'b1, "R10", "collision", {31'd0, q_o}, 32'd1);
    issue(0, 0, 0, 0, 0, 0, 0, 1, "R10");

    // sweep: R2 R3 R4 R5 R6 R7 R8 R9 R10
    begin
      int n;
      n = 0;
      for (int ia0 = 0; ia0 < 7; ia0++)
        for (int ia1 = 0; ia1 < 7; ia1++)
          for (int ib0 = 0; ib0 < 7; ib0++)
            for (int ib1 = 0; ib1 < 7; ib1++)
              for (int m = 0; m < 8; m++) begin
                string tg;
                tg = m[2] ? "R5" : (m[0] ? "R4" : (m[1] ? "R3" : "R2"));
                issue(1, {vals[ia1], vals[ia0]}, {vals[ib1], vals[ib0]},
                      cvals[n % 4], m[0], m[1], m[2], (n % 7) == 0, tg);
                n++;
              end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule